// File: doc/BRIEF.md
# I2C Register-Access Target with Atomic Write Commit

This block is an I2C target that lets a host reach an internal byte-wide register file through a 16-bit register pointer. The host addresses the target with one of four 7-bit addresses, picked by a 2-bit select input. It loads the pointer with two bytes and then streams data bytes in or out. The pointer advances after every byte, so one transfer covers a run of consecutive registers.

Incoming write bytes do not reach the register file one at a time. They are held in a small staging buffer. When the host issues STOP, the whole block is presented to the register file in a single-cycle wide write: a base address, a byte count and a packed data vector. Any register observer therefore sees either none of a block or all of it. A repeated START abandons the staged bytes, and so does a transfer that never addresses this target. The register file is read through a plain combinational address/data port that follows the pointer.

The SDA line is open-drain: the block only pulls it low through an output enable. SCL is an input only. Both lines pass through a two-flop synchroniser, and START and STOP are recognised as SDA edges while SCL is high.

Top module: `i2c_regfile_target`

## Requirements
- R1: The target responds only to the 7-bit address 0x68 + `addr_sel` (0x68..0x6B). The 7 address bits are sent MSB first and are followed by a R/W bit, where 0 means write. A matching address byte is ACKed (SDA pulled low in the ninth clock). For any other address the target leaves SDA released for the rest of the transfer and commits nothing.
- R2: In a write transfer, the two bytes after the address byte load the 16-bit register pointer, high byte first.
- R3: Data bytes are taken MSB first and assigned to consecutive register addresses starting at the pointer. Byte i of a commit sits in `wr_data[8*i+7:8*i]` and belongs to address `wr_base + i`.
- R4: No register write happens before STOP. At STOP, one `wr_en` pulse of a single cycle carries every staged byte of the block, with `wr_count` giving their number. A block with no data bytes produces no pulse.
- R5: The staging buffer holds 16 bytes. Further bytes in the same block are still ACKed but are dropped, so `wr_count` never exceeds 16.
- R6: A repeated START discards any staged bytes without committing them. A repeated START followed by a read address starts reading at the pointer that was just loaded.
- R7: A read returns the register at the pointer, MSB first, and then the following registers, one per byte, for as long as the host ACKs.
- R8: When the host NACKs a read byte, the target releases SDA and ignores SCL activity until the next START or STOP.
- R9: The pointer wraps from 0xFFFF to 0x0000 on both reads and writes.
- R10: A byte cut short by STOP is discarded. Only complete bytes are committed.
- R11: After reset, SDA is released and no write is issued.
- R12: The target ACKs each pointer byte and each data byte of a write addressed to it, and it starts driving SDA only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| addr_sel | input | 2 | Selects the target address 0x68 + addr_sel |
| rd_addr | output | 16 | Register file read address (current pointer) |
| rd_data | input | 8 | Register file read data, combinational from rd_addr |
| wr_en | output | 1 | One-cycle commit strobe |
| wr_base | output | 16 | Register address of the first committed byte |
| wr_count | output | 5 | Number of valid bytes in the commit |
| wr_data | output | 128 | Committed bytes, byte i at bits 8i+7..8i |

## Verification
Several properties are checked on every cycle. A commit pulse always follows a detected STOP, carries between 1 and 16 bytes, and the staging count returns to zero after every START. SDA is only ever pulled low starting in a cycle where SCL is low. A staged byte is pushed only on a falling SCL edge, and the target never drives the line while it waits out a NACKed read. Only the bench scenarios can show the rest: that data lands at the right addresses in the right order, that pointer wrap, the 16-byte overflow, a partial byte and an abandoned block leave the register file as predicted, and that the wrong address gets no ACK.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int PTR_W = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_TXACK,
    ST_WAIT
  } tgt_state_t;

  typedef enum logic [1:0] {
    K_ADDR,
    K_PTRH,
    K_PTRL,
    K_DATA
  } rx_kind_t;
endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_pipe;
  logic [SYNC_STAGES-1:0] sda_pipe;
  logic scl_q;
  logic sda_q;

  // bus idles high, so every stage resets to 1 to avoid a false edge
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        scl_pipe[g] <= 1'b1;
        sda_pipe[g] <= 1'b1;
      end else if (g == 0) begin
        scl_pipe[g] <= scl_i;
        sda_pipe[g] <= sda_i;
      end else begin
        scl_pipe[g] <= scl_pipe[(g == 0) ? 0 : g-1];
        sda_pipe[g] <= sda_pipe[(g == 0) ? 0 : g-1];
      end
    end
  end

  assign scl_s = scl_pipe[SYNC_STAGES-1];
  assign sda_s = sda_pipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_comb begin
    scl_rise  = scl_s & ~scl_q;
    scl_fall  = ~scl_s & scl_q;
    start_det = scl_s & scl_q & sda_q & ~sda_s;
    stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  end
endmodule

// File: rtl/i2cs_stage_buf.sv
module i2cs_stage_buf #(
  parameter int DEPTH = 16,
  parameter int AW    = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              commit,
  input  logic              push,
  input  logic [AW-1:0]     push_addr,
  input  logic [7:0]        push_data,
  output logic              wr_en,
  output logic [AW-1:0]     wr_base,
  output logic [CW-1:0]     wr_count,
  output logic [DEPTH*8-1:0] wr_data
);
  logic [CW-1:0] cnt_q, cnt_n;
  logic [AW-1:0] base_q, base_n;
  logic          wr_en_n;
  logic          room;

  assign room = (cnt_q < CW'(DEPTH));

  always_comb begin
    cnt_n   = cnt_q;
    base_n  = base_q;
    wr_en_n = 1'b0;
    if (clear) begin
      cnt_n = '0;
    end else if (commit) begin
      wr_en_n = (cnt_q != '0);
      cnt_n   = '0;
    end else if (push && room) begin
      cnt_n = cnt_q + CW'(1);
      if (cnt_q == '0) base_n = push_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      base_q   <= '0;
      wr_en    <= 1'b0;
      wr_base  <= '0;
      wr_count <= '0;
    end else begin
      cnt_q <= cnt_n;
      base_q <= base_n;
      wr_en <= wr_en_n;
      if (wr_en_n) begin
        wr_base  <= base_q;
        wr_count <= cnt_q;
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [7:0] ent_q;
    logic       ent_ld;
    assign ent_ld = push && !clear && !commit && (cnt_q == CW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q <= '0;
      else if (ent_ld) ent_q <= push_data;
    end
    assign wr_data[g*8 +: 8] = ent_q;
  end

  AST_COMMIT_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(commit)); // R4
  AST_COMMIT_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_count != '0 && wr_count <= CW'(DEPTH))); // R5
  AST_STAGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH)); // R5
  AST_START_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0)); // R6
endmodule

// File: rtl/i2cs_proto.sv
module i2cs_proto
  import i2cs_pkg::*;
#(
  parameter logic [6:0] DEV_BASE = 7'h68
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             sda_s,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [1:0]       addr_sel,
  input  logic [7:0]       rd_data,
  output logic             sda_oe,
  output logic [PTR_W-1:0] ptr,
  output logic             push,
  output logic [PTR_W-1:0] push_addr,
  output logic [7:0]       push_data
);
  tgt_state_t st_q, st_n;
  rx_kind_t   kind_q, kind_n;
  logic [3:0] bcnt_q, bcnt_n;
  logic [7:0] sh_q, sh_n;
  logic [PTR_W-1:0] ptr_q, ptr_n;
  logic       oe_q, oe_n;
  logic       hack_q, hack_n;
  logic [6:0] dev_addr;
  logic       byte_done;

  assign dev_addr  = DEV_BASE + {5'b0, addr_sel};
  assign byte_done = scl_fall && (bcnt_q == 4'd8);

  always_comb begin
    st_n   = st_q;
    kind_n = kind_q;
    bcnt_n = bcnt_q;
    sh_n   = sh_q;
    ptr_n  = ptr_q;
    oe_n   = oe_q;
    hack_n = hack_q;
    push   = 1'b0;
    if (start_det) begin
      st_n   = ST_RX;
      kind_n = K_ADDR;
      bcnt_n = '0;
      oe_n   = 1'b0;
    end else if (stop_det) begin
      st_n = ST_IDLE;
      oe_n = 1'b0;
    end else begin
      unique case (st_q)
        ST_RX: begin
          if (scl_rise && bcnt_q < 4'd8) begin
            sh_n   = {sh_q[6:0], sda_s};
            bcnt_n = bcnt_q + 4'd1;
          end
          if (byte_done) begin
            unique case (kind_q)
              K_ADDR: begin
                if (sh_q[7:1] == dev_addr) begin
                  st_n = ST_ACK;
                  oe_n = 1'b1;
                end else begin
                  st_n = ST_WAIT;
                end
              end
              K_PTRH: begin
                ptr_n = {sh_q, ptr_q[7:0]};
                st_n  = ST_ACK;
                oe_n  = 1'b1;
              end
              K_PTRL: begin
                ptr_n = {ptr_q[15:8], sh_q};
                st_n  = ST_ACK;
                oe_n  = 1'b1;
              end
              default: begin
                push  = 1'b1;
                ptr_n = ptr_q + PTR_W'(1);
                st_n  = ST_ACK;
                oe_n  = 1'b1;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bcnt_n = '0;
            if (kind_q == K_ADDR && sh_q[0]) begin
              st_n = ST_TX;
              sh_n = rd_data;
              oe_n = ~rd_data[7];
            end else begin
              st_n = ST_RX;
              oe_n = 1'b0;
              unique case (kind_q)
                K_ADDR:  kind_n = K_PTRH;
                K_PTRH:  kind_n = K_PTRL;
                default: kind_n = K_DATA;
              endcase
            end
          end
        end
        ST_TX: begin
          if (scl_rise) bcnt_n = bcnt_q + 4'd1;
          if (scl_fall) begin
            if (bcnt_q == 4'd8) begin
              oe_n  = 1'b0;
              st_n  = ST_TXACK;
              ptr_n = ptr_q + PTR_W'(1);
            end else begin
              sh_n = {sh_q[6:0], 1'b0};
              oe_n = ~sh_q[6];
            end
          end
        end
        ST_TXACK: begin
          if (scl_rise) hack_n = ~sda_s;
          if (scl_fall) begin
            if (hack_q) begin
              st_n   = ST_TX;
              bcnt_n = '0;
              sh_n   = rd_data;
              oe_n   = ~rd_data[7];
            end else begin
              st_n = ST_WAIT;
              oe_n = 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      kind_q <= K_ADDR;
      bcnt_q <= '0;
      sh_q   <= '0;
      ptr_q  <= '0;
      oe_q   <= 1'b0;
      hack_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      kind_q <= kind_n;
      bcnt_q <= bcnt_n;
      sh_q   <= sh_n;
      ptr_q  <= ptr_n;
      oe_q   <= oe_n;
      hack_q <= hack_n;
    end
  end

  assign sda_oe    = oe_q;
  assign ptr       = ptr_q;
  assign push_addr = ptr_q;
  assign push_data = sh_q;

  AST_DRIVE_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> !scl_s); // R12
  AST_PUSH_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> scl_fall); // R10
  AST_WAIT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT) |-> !oe_q); // R8
endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target #(
  parameter logic [6:0] DEV_BASE    = 7'h68,
  parameter int         STAGE_DEPTH = 16,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               scl_i,
  input  logic                               sda_i,
  output logic                               sda_oe,
  input  logic [1:0]                         addr_sel,
  output logic [15:0]                        rd_addr,
  input  logic [7:0]                         rd_data,
  output logic                               wr_en,
  output logic [15:0]                        wr_base,
  output logic [$clog2(STAGE_DEPTH+1)-1:0]   wr_count,
  output logic [STAGE_DEPTH*8-1:0]           wr_data
);
  logic [1:0] rst_pipe;
  logic       rst_int_n;
  logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic       push;
  logic [15:0] push_addr;
  logic [7:0]  push_data;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  i2cs_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2cs_proto #(.DEV_BASE(DEV_BASE)) u_proto (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .scl_s     (scl_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_s     (sda_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .addr_sel  (addr_sel),
    .rd_data   (rd_data),
    .sda_oe    (sda_oe),
    .ptr       (rd_addr),
    .push      (push),
    .push_addr (push_addr),
    .push_data (push_data)
  );

  i2cs_stage_buf #(.DEPTH(STAGE_DEPTH), .AW(16)) u_stage (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clear     (start_det),
    .commit    (stop_det),
    .push      (push),
    .push_addr (push_addr),
    .push_data (push_data),
    .wr_en     (wr_en),
    .wr_base   (wr_base),
    .wr_count  (wr_count),
    .wr_data   (wr_data)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_int_n |-> (!sda_oe && !wr_en)); // R11
endmodule

// File: tb/i2c_regfile_target_tb.sv
module i2c_regfile_target_tb;
  localparam int Q = 4;
  localparam int WD_LIMIT = 190000;

  logic clk = 1'b0;
  logic rst_n;
  logic h_scl_low, h_sda_low;
  logic sda_bus, scl_bus;
  logic sda_oe;
  logic [1:0] addr_sel;
  logic [15:0] rd_addr;
  logic [7:0] rd_data;
  logic wr_en;
  logic [15:0] wr_base;
  logic [4:0] wr_count;
  logic [127:0] wr_data;

  logic [7:0] mem [0:255];
  logic [7:0] sh_mem [0:255];
  logic [7:0] wbuf [0:31];
  int n_commit;
  logic [15:0] last_base;
  logic [4:0] last_cnt;
  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #10ns clk = ~clk;

  assign scl_bus = ~h_scl_low;
  assign sda_bus = ~(h_sda_low | sda_oe);
  assign rd_data = mem[rd_addr[7:0]] ^ rd_addr[15:8];

  i2c_regfile_target u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .rd_addr(rd_addr), .rd_data(rd_data), .wr_en(wr_en),
    .wr_base(wr_base), .wr_count(wr_count), .wr_data(wr_data)
  );

  // register file model
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 13 + 5);
      n_commit <= 0;
    end else if (wr_en) begin
      n_commit  <= n_commit + 1;
      last_base <= wr_base;
      last_cnt  <= wr_count;
      for (int i = 0; i < 16; i++) begin
        if (i < int'(wr_count)) begin : wr_one
          logic [15:0] a;
          a = wr_base + 16'(i);
          mem[a[7:0]] <= wr_data[8*i +: 8] ^ a[15:8];
        end
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, WD_LIMIT);
      summary();
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [15:0] a);
    return sh_mem[a[7:0]] ^ a[15:8];
  endfunction

  task automatic shadow_wr(input logic [15:0] p, input int n);
    for (int i = 0; i < n && i < 16; i++) begin
      logic [15:0] a;
      a = p + 16'(i);
      sh_mem[a[7:0]] = wbuf[i] ^ a[15:8];
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    h_sda_low = ~b; wq();
    h_scl_low = 1'b0; wq(); wq();
    h_scl_low = 1'b1; wq();
  endtask

  task automatic i2c_start();
    h_sda_low = 1'b0; wq();
    h_scl_low = 1'b0; wq();
    h_sda_low = 1'b1; wq();
    h_scl_low = 1'b1; wq();
  endtask

  task automatic i2c_stop();
    h_sda_low = 1'b1; wq();
    h_scl_low = 1'b0; wq();
    h_sda_low = 1'b0; wq();
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    h_sda_low = 1'b0; wq();
    h_scl_low = 1'b0; wq();
    ack = ~sda_bus; wq();
    h_scl_low = 1'b1; wq();
  endtask

  task automatic rd_byte(input logic host_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      h_sda_low = 1'b0; wq();
      h_scl_low = 1'b0; wq();
      b[i] = sda_bus; wq();
      h_scl_low = 1'b1; wq();
    end
    send_bit(~host_ack);
  endtask

  task automatic wr_hdr(input logic [6:0] a7, input logic [15:0] p, inout int acks);
    logic k;
    i2c_start();
    wr_byte({a7, 1'b0}, k); acks += int'(k);
    wr_byte(p[15:8], k);    acks += int'(k);
    wr_byte(p[7:0], k);     acks += int'(k);
  endtask

  task automatic do_write(input logic [6:0] a7, input logic [15:0] p, input int n, output int acks);
    logic k;
    acks = 0;
    wr_hdr(a7, p, acks);
    for (int i = 0; i < n; i++) begin
      wr_byte(wbuf[i], k);
      acks += int'(k);
    end
    i2c_stop();
  endtask

  task automatic do_read(input logic [6:0] a7, input logic [15:0] p, input int n, input string tag);
    logic k;
    logic [7:0] b;
    int acks;
    int bad;
    acks = 0;
    bad = 0;
    wr_hdr(a7, p, acks);
    i2c_start();
    wr_byte({a7, 1'b1}, k);
    chk({tag, " read header acked"}, acks + int'(k), 4);
    for (int i = 0; i < n; i++) begin
      rd_byte(i != n - 1, b);
      if (b !== exp_rd(p + 16'(i))) begin
        bad++;
        $display("FAIL %s byte %0d at %0h actual=%0h expected=%0h", tag, i, p + 16'(i), b, exp_rd(p + 16'(i)));
      end
    end
    i2c_stop();
    chk({tag, " read data mismatches"}, bad, 0);
  endtask

  initial begin
    int acks;
    int c0;
    int quiet_bad;
    logic k;
    h_scl_low = 1'b0;
    h_sda_low = 1'b0;
    addr_sel  = 2'd0;
    rst_n     = 1'b0;
    for (int i = 0; i < 256; i++) sh_mem[i] = 8'(i * 13 + 5);
    repeat (6) @(negedge clk);
    // R11: reset state
    chk("R11 sda released in reset", sda_oe, 0);
    chk("R11 no write in reset", wr_en, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R11 sda released after reset", sda_oe, 0);
    chk("R11 no commit after reset", n_commit, 0);

    // R2 R3 R4: basic block write, commit only at STOP
    wbuf[0] = 8'hA5; wbuf[1] = 8'h3C; wbuf[2] = 8'h81;
    acks = 0;
    wr_hdr(7'h68, 16'h0110, acks);
    for (int i = 0; i < 3; i++) begin wr_byte(wbuf[i], k); acks += int'(k); end
    chk("R12 pointer and data bytes acked", acks, 6);
    chk("R4 no commit before STOP", n_commit, 0);
    i2c_stop();
    repeat (4) @(negedge clk);
    chk("R4 one commit at STOP", n_commit, 1);
    chk("R3 commit count", last_cnt, 3);
    chk("R2 commit base from pointer bytes", last_base, 16'h0110);
    shadow_wr(16'h0110, 3);
    do_read(7'h68, 16'h0110, 3, "R7 R3");

    // R1: alternate select and wrong address
    addr_sel = 2'd2;
    wbuf[0] = 8'h5A; wbuf[1] = 8'hC3;
    do_write(7'h6A, 16'h0020, 2, acks);
    chk("R1 select 2 acked at 0x6A", acks, 5);
    shadow_wr(16'h0020, 2);
    do_read(7'h6A, 16'h0020, 2, "R1 readback");
    c0 = n_commit;
    wbuf[0] = 8'hFF; wbuf[1] = 8'h00;
    do_write(7'h68, 16'h0020, 2, acks);
    repeat (4) @(negedge clk);
    chk("R1 wrong address never acked", acks, 0);
    chk("R1 wrong address commits nothing", n_commit, c0);
    addr_sel = 2'd3;
    do_write(7'h6B, 16'h0030, 0, acks);
    repeat (4) @(negedge clk);
    chk("R1 select 3 acked at 0x6B", acks, 3);
    chk("R4 empty block gives no commit", n_commit, c0);

    // R5: overflow beyond 16 bytes
    addr_sel = 2'd0;
    for (int i = 0; i < 20; i++) wbuf[i] = 8'(8'h40 + i * 3);
    do_write(7'h68, 16'h0040, 20, acks);
    repeat (4) @(negedge clk);
    chk("R5 extra bytes still acked", acks, 23);
    chk("R5 commit limited to 16", last_cnt, 16);
    shadow_wr(16'h0040, 20);
    do_read(7'h68, 16'h0040, 20, "R5 overflow readback");

    // R6: repeated START abandons staged bytes
    c0 = n_commit;
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    acks = 0;
    wr_hdr(7'h68, 16'h0080, acks);
    wr_byte(8'h11, k); wr_byte(8'h22, k);
    wr_hdr(7'h68, 16'h0090, acks);
    wr_byte(8'h77, k);
    i2c_stop();
    repeat (4) @(negedge clk);
    chk("R6 only second block commits", n_commit - c0, 1);
    chk("R6 second block count", last_cnt, 1);
    chk("R6 second block base", last_base, 16'h0090);
    wbuf[0] = 8'h77;
    shadow_wr(16'h0090, 1);
    do_read(7'h68, 16'h0080, 2, "R6 abandoned bytes untouched");
    do_read(7'h68, 16'h0090, 1, "R6 second block data");

    // R9: pointer wrap on write and read
    wbuf[0] = 8'hDE; wbuf[1] = 8'hAD; wbuf[2] = 8'hBE;
    do_write(7'h68, 16'hFFFF, 3, acks);
    repeat (4) @(negedge clk);
    chk("R9 wrap commit base", last_base, 16'hFFFF);
    shadow_wr(16'hFFFF, 3);
    do_read(7'h68, 16'hFFFE, 4, "R9 wrap readback");

    // R10: partial byte discarded
    wbuf[0] = 8'h9A; wbuf[1] = 8'h6B;
    acks = 0;
    wr_hdr(7'h68, 16'h00A0, acks);
    wr_byte(8'h9A, k); wr_byte(8'h6B, k);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    i2c_stop();
    repeat (4) @(negedge clk);
    chk("R10 partial byte dropped", last_cnt, 2);
    shadow_wr(16'h00A0, 2);
    do_read(7'h68, 16'h00A0, 3, "R10 readback");

    // R8: after host NACK the line stays released
    begin
      logic [7:0] b;
      acks = 0;
      wr_hdr(7'h68, 16'h0005, acks);
      i2c_start();
      wr_byte({7'h68, 1'b1}, k);
      rd_byte(1'b0, b);
      chk("R7 first read byte", b, exp_rd(16'h0005));
      quiet_bad = 0;
      for (int i = 0; i < 9; i++) begin
        h_sda_low = 1'b0; wq();
        h_scl_low = 1'b0; wq();
        if (sda_bus !== 1'b1) quiet_bad++;
        wq();
        h_scl_low = 1'b1; wq();
      end
      i2c_stop();
      chk("R8 sda released after NACK", quiet_bad, 0);
    end

    // random blocks against the shadow model
    void'($urandom(32'd20240611));
    for (int t = 0; t < 14; t++) begin
      logic [15:0] p;
      int n;
      addr_sel = 2'($urandom);
      p = 16'($urandom);
      n = 1 + int'($urandom % 18);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      c0 = n_commit;
      do_write(7'h68 + {5'b0, addr_sel}, p, n, acks);
      repeat (4) @(negedge clk);
      chk("R12 random block acked", acks, n + 3);
      chk("R4 random single commit", n_commit - c0, 1);
      chk("R5 random commit count", last_cnt, (n > 16) ? 16 : n);
      shadow_wr(p, n);
      do_read(7'h68 + {5'b0, addr_sel}, p, n, "R7 random readback");
    end

    summary();
    $finish;
  end
endmodule